// File: doc/BRIEF.md
# Per-Thread Instruction Fetch Window Buffer

This block keeps one window of instruction bytes for each hardware thread. For each window it also records the address of the window's first byte and whether the window holds usable data. The instruction-cache side loads a window with a fill: a thread number, a start PC, a byte count and a wide data bus. The fetch logic then asks combinational questions about one thread at a time. Does a PC fall inside that thread's window? If so, at which byte offset? Which instruction bytes begin there? Where does the window end?

The default window is 66 bytes, which is one 64-byte cache line plus two bytes. A 4-byte instruction that starts at offset 62 of a line can therefore be served from a single window. Every thread slot is a two-state machine. `SLOT_EMPTY` moves to `SLOT_LOADED` on the LOAD transition, which is a fill without a flush of the same thread. `SLOT_LOADED` stays in `SLOT_LOADED` on a RELOAD, which is another such fill. Either state goes to `SLOT_EMPTY` on the CLEAR transition, which is a flush of that thread or reset. A flush and a fill for the same thread in the same cycle take the CLEAR transition.

Top module: `fetch_window_buf`

## Requirements
- R1: Each thread has its own slot. A fill or flush addressed to one thread leaves the hit, offset, bytes and end address reported for every other thread unchanged.
- R2: The query hits (`q_hit`=1) only when the queried slot is loaded, `q_pc` >= the start, and `q_pc` < start + WIN_BYTES. The comparison does not wrap: a PC numerically below the start misses.
- R3: On a hit, `q_offset` equals `q_pc` minus the start.
- R4: On a miss, `q_hit` is 0, `q_offset` is 0 and `q_insn` is 0.
- R5: A fill sets the thread's start to `fill_pc` and marks the slot loaded. It writes window byte i from `fill_data[8i+7:8i]` for every i < `fill_len`. Bytes at or beyond `fill_len` keep their earlier contents.
- R6: Reset and flush return the slot to empty and zero its start, but leave its data bytes untouched. A later fill with `fill_len`=0 exposes the retained bytes.
- R7: `q_end` is the queried thread's start + WIN_BYTES, modulo 2^ADDR_W. This holds whether or not the slot is loaded.
- R8: When a fill and a flush target the same thread in the same cycle, the slot ends empty and its start is zero. A flush of a different thread does not block the fill.
- R9: On a hit, `q_insn` byte k (bits 8k+7:8k) is window byte `q_offset`+k. Any byte whose index reaches WIN_BYTES or more reads as 0. With the defaults, a hit at offset 62 returns four window bytes.
- R10: A fill or flush applied at a rising clock edge is visible at the query outputs right after that edge. Queries have no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Load a window this cycle |
| fill_tid | input | $clog2(NUM_THREADS) | Thread receiving the fill |
| fill_pc | input | ADDR_W | Start address of the filled window |
| fill_data | input | 8*WIN_BYTES | Fill bytes, byte i at bits 8i+7:8i |
| fill_len | input | $clog2(WIN_BYTES+1) | Number of leading bytes to write |
| flush | input | NUM_THREADS | Per-thread clear, bit t for thread t |
| q_tid | input | $clog2(NUM_THREADS) | Thread being queried |
| q_pc | input | ADDR_W | PC being queried |
| q_hit | output | 1 | PC lies inside the loaded window |
| q_offset | output | $clog2(WIN_BYTES) | Byte offset of the PC on a hit, else 0 |
| q_insn | output | 8*INSN_BYTES | Bytes starting at the offset, 0 past the window |
| q_end | output | ADDR_W | Window start plus WIN_BYTES |

## Verification
The bench builds the block with four threads and 16-bit addresses, keeping the default 66-byte window and 4-byte instruction slice. The 16-bit address width makes the top of the address space reachable in a few steps. The bench places a window at 0xFFF0, so the end address wraps to 0x0032 and a PC just above zero must still miss. Four threads let one test flush one slot, fill another and race a fill against a flush on a third while a fourth stays idle. The default window size puts the tail offsets 62 to 65, and the zero bytes returned past the window end, within reach.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
    typedef enum logic {
        SLOT_EMPTY  = 1'b0,
        SLOT_LOADED = 1'b1
    } slot_state_e;
endpackage

// File: rtl/fwb_slot.sv
module fwb_slot
    import fwb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIN_BYTES = 66,
    parameter int LEN_W     = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_pc,
    input  logic [8*WIN_BYTES-1:0] wr_data,
    input  logic [LEN_W-1:0]       wr_len,
    input  logic                   clr,
    output logic                   valid,
    output logic [ADDR_W-1:0]      start,
    output logic [8*WIN_BYTES-1:0] data
);
    slot_state_e state_q, state_d;
    logic        take_fill;

    // A flush of this slot outranks a fill of it (R8)
    assign take_fill = wr_en && !clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY:  if (take_fill) state_d = SLOT_LOADED;   // LOAD
            SLOT_LOADED: if (clr)       state_d = SLOT_EMPTY;    // CLEAR
                         else if (take_fill) state_d = SLOT_LOADED; // RELOAD
            default:     state_d = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) start <= '0;
        else if (take_fill) start <= wr_pc;
    end

    // Data bytes carry no reset; only the leading wr_len bytes are written
    always_ff @(posedge clk) begin
        for (int i = 0; i < WIN_BYTES; i++) begin
            if (rst_n && take_fill && (LEN_W'(i) < wr_len))
                data[8*i +: 8] <= wr_data[8*i +: 8];
        end
    end

    assign valid = (state_q == SLOT_LOADED);

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr) |=> (!valid && start == '0));
    assert_fill_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (valid && start == $past(wr_pc)));
    assert_empty_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (start == '0));
    assert_flush_keeps_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && $past(rst_n)) |=> $stable(data));
endmodule

// File: rtl/fwb_window_check.sv
module fwb_window_check #(
    parameter int ADDR_W     = 32,
    parameter int WIN_BYTES  = 66,
    parameter int INSN_BYTES = 4,
    parameter int OFF_W      = 7
) (
    input  logic                    valid,
    input  logic [ADDR_W-1:0]       start,
    input  logic [8*WIN_BYTES-1:0]  data,
    input  logic [ADDR_W-1:0]       pc,
    output logic                    hit,
    output logic [OFF_W-1:0]        offset,
    output logic [8*INSN_BYTES-1:0] insn,
    output logic [ADDR_W-1:0]       win_end
);
    localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0]      diff;
    logic [8*WIN_BYTES-1:0] shifted;

    assign diff    = pc - start;
    assign hit     = valid && (pc >= start) && (diff < WIN_A);
    assign offset  = hit ? diff[OFF_W-1:0] : '0;
    assign win_end = start + WIN_A;
    assign shifted = data >> (8 * int'(offset));

    always_comb begin
        insn = '0;
        for (int k = 0; k < INSN_BYTES; k++) begin
            if (hit && (int'(offset) + k < WIN_BYTES))
                insn[8*k +: 8] = shifted[8*k +: 8];
        end
    end
endmodule

// File: rtl/fetch_window_buf.sv
module fetch_window_buf #(
    parameter int NUM_THREADS = 2,
    parameter int ADDR_W      = 32,
    parameter int WIN_BYTES   = 66,
    parameter int INSN_BYTES  = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               fill_valid,
    input  logic [$clog2(NUM_THREADS)-1:0]     fill_tid,
    input  logic [ADDR_W-1:0]                  fill_pc,
    input  logic [8*WIN_BYTES-1:0]             fill_data,
    input  logic [$clog2(WIN_BYTES+1)-1:0]     fill_len,
    input  logic [NUM_THREADS-1:0]             flush,
    input  logic [$clog2(NUM_THREADS)-1:0]     q_tid,
    input  logic [ADDR_W-1:0]                  q_pc,
    output logic                               q_hit,
    output logic [$clog2(WIN_BYTES)-1:0]       q_offset,
    output logic [8*INSN_BYTES-1:0]            q_insn,
    output logic [ADDR_W-1:0]                  q_end
);
    localparam int TID_W = $clog2(NUM_THREADS);
    localparam int LEN_W = $clog2(WIN_BYTES + 1);
    localparam int OFF_W = $clog2(WIN_BYTES);

    logic                   slot_valid [NUM_THREADS];
    logic [ADDR_W-1:0]      slot_start [NUM_THREADS];
    logic [8*WIN_BYTES-1:0] slot_data  [NUM_THREADS];

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        fwb_slot #(
            .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .LEN_W(LEN_W)
        ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (fill_valid && (fill_tid == TID_W'(t))),
            .wr_pc   (fill_pc),
            .wr_data (fill_data),
            .wr_len  (fill_len),
            .clr     (flush[t]),
            .valid   (slot_valid[t]),
            .start   (slot_start[t]),
            .data    (slot_data[t])
        );
    end

    fwb_window_check #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
        .INSN_BYTES(INSN_BYTES), .OFF_W(OFF_W)
    ) i_check (
        .valid   (slot_valid[q_tid]),
        .start   (slot_start[q_tid]),
        .data    (slot_data[q_tid]),
        .pc      (q_pc),
        .hit     (q_hit),
        .offset  (q_offset),
        .insn    (q_insn),
        .win_end (q_end)
    );

    assert_hit_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_hit |-> (slot_valid[q_tid] && q_pc >= slot_start[q_tid]
                   && int'(q_offset) < WIN_BYTES));
    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q_hit |-> (q_offset == '0 && q_insn == '0));
    assert_offset_adds_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q_hit |-> (slot_start[q_tid] + ADDR_W'(q_offset) == q_pc));
endmodule

// File: tb/test_fetch_window_buf.sv
module test_fetch_window_buf;
    localparam int NT = 4, AW = 16, WB = 66, IB = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fill_valid = 1'b0;
    logic [1:0] fill_tid = '0;
    logic [AW-1:0] fill_pc = '0;
    logic [8*WB-1:0] fill_data = '0;
    logic [6:0] fill_len = '0;
    logic [NT-1:0] flush = '0;
    logic [1:0] q_tid = '0;
    logic [AW-1:0] q_pc = '0;
    logic q_hit;
    logic [6:0] q_offset;
    logic [8*IB-1:0] q_insn;
    logic [AW-1:0] q_end;

    int checks = 0, errors = 0;
    logic [7:0] m_data [NT][WB];
    logic [AW-1:0] m_start [NT];
    logic m_valid [NT];

    always #2 clk = ~clk;

    fetch_window_buf #(.NUM_THREADS(NT), .ADDR_W(AW), .WIN_BYTES(WB), .INSN_BYTES(IB))
    i_fetch_window_buf (.*);

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic query(int t, logic [AW-1:0] pc, string req);
        logic [AW-1:0] d;
        logic h;
        logic [31:0] ins;
        q_tid = 2'(t); q_pc = pc; #1;
        d = pc - m_start[t];
        h = m_valid[t] && pc >= m_start[t] && d < AW'(WB);
        ins = '0;
        for (int k = 0; k < IB; k++)
            if (h && int'(d) + k < WB) ins[8*k +: 8] = m_data[t][int'(d) + k];
        chk(req, 64'(q_hit), 64'(h));
        chk(req, 64'(q_offset), h ? 64'(d) : 64'd0);
        chk(req, 64'(q_insn), 64'(ins));
        chk(req, 64'(q_end), 64'(AW'(m_start[t] + AW'(WB))));
    endtask

    // one clock of fill and/or flush; model updated afterwards
    task automatic step(bit fv, int ft, logic [AW-1:0] pc, int len, logic [7:0] seed,
                        logic [NT-1:0] fl);
        @(negedge clk);
        fill_valid = fv; fill_tid = 2'(ft); fill_pc = pc; fill_len = 7'(len); flush = fl;
        for (int i = 0; i < WB; i++) fill_data[8*i +: 8] = seed + 8'(i * 3);
        @(negedge clk);
        fill_valid = 1'b0; flush = '0;
        for (int t = 0; t < NT; t++) begin
            if (fl[t]) begin m_valid[t] = 1'b0; m_start[t] = '0; end
            else if (fv && ft == t) begin
                m_valid[t] = 1'b1; m_start[t] = pc;
                for (int i = 0; i < len && i < WB; i++) m_data[t][i] = seed + 8'(i * 3);
            end
        end
    endtask

    task automatic t_reset();
        for (int t = 0; t < NT; t++) begin m_valid[t] = 0; m_start[t] = '0; end
        for (int t = 0; t < NT; t++) query(t, 16'h0000, "R2 reset miss");
        query(0, 16'h0040, "R4 reset miss");
    endtask

    task automatic t_basic();
        step(1, 0, 16'h1000, WB, 8'h10, '0);
        query(0, 16'h1000, "R10 R3 first byte");
        query(0, 16'h1011, "R3 mid");
        query(0, 16'h0FFF, "R2 below start");
        query(0, 16'h1041, "R2 last byte");
        query(0, 16'h1042, "R2 end excluded R4");
    endtask

    task automatic t_tail();
        query(0, 16'h103E, "R9 offset 62");
        query(0, 16'h103F, "R9 offset 63 zero pad");
        chk("R9 top byte zero", 64'(q_insn[31:24]), 64'd0);
        query(0, 16'h1040, "R9 offset 64");
    endtask

    task automatic t_partial();
        step(1, 1, 16'h2000, WB, 8'h40, '0);
        step(1, 1, 16'h3000, 4, 8'hA0, '0);
        query(1, 16'h3000, "R5 new bytes");
        query(1, 16'h3002, "R5 mixed bytes");
        query(1, 16'h3010, "R5 old bytes kept");
        query(1, 16'h2000, "R5 old start miss");
    endtask

    task automatic t_flush();
        step(0, 0, '0, 0, 8'h0, 4'b0010);
        query(1, 16'h3000, "R6 flushed miss");
        chk("R6 end after flush", 64'(q_end), 64'(AW'(WB)));
        step(1, 1, 16'h5000, 0, 8'hEE, '0);
        query(1, 16'h5008, "R6 data retained");
    endtask

    task automatic t_race();
        step(1, 2, 16'h6000, WB, 8'h55, '0);
        step(1, 2, 16'h7000, WB, 8'h77, 4'b0100);
        query(2, 16'h7000, "R8 flush wins");
        query(2, 16'h6000, "R8 old window gone");
        step(1, 3, 16'h8000, WB, 8'h99, 4'b0001);
        query(3, 16'h8020, "R8 other flush no block");
        query(0, 16'h1000, "R8 R1 thread0 flushed");
    endtask

    task automatic t_threads();
        step(1, 0, 16'h9000, WB, 8'h21, '0);
        query(3, 16'h8020, "R1 thread3 unchanged");
        query(1, 16'h5008, "R1 thread1 unchanged");
        query(0, 16'h9020, "R1 thread0 own");
    endtask

    task automatic t_wrap();
        step(1, 3, 16'hFFF0, WB, 8'h03, '0);
        query(3, 16'hFFFF, "R7 hit near top");
        chk("R7 end wraps", 64'(q_end), 64'h0032);
        query(3, 16'h0010, "R2 no wrap hit");
    endtask

    initial begin
        t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_tail();
        t_partial();
        t_flush();
        t_race();
        t_threads();
        t_wrap();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule